// File: doc/BRIEF.md
# Address Segment and Privilege Checker

This block screens every memory request before it reaches the translation lookaside buffer. From the processor status word it works out the current privilege level. From the top bits of the virtual address it decides whether the request falls into one of the two unmapped windows, which bypass translation through a fixed mapping, or into mapped space, which must be sent on to the TLB. It also flags requests that must not be cached and raises an address error for bad accesses to the privileged cached window.

The decision logic is combinational. All results are captured in one output register stage, so they appear together one clock after a request is presented. A cycle without a request yields an all-zero output word.

Top module: `addr_seg_check`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, every output is zero.
- R2: `priv_mode` is kernel (code 0) when any of status bits 28, 2 or 1 is set, or when status bits [4:3] are 00.
- R3: With none of bits 28, 2, 1 set, status bits [4:3] of 01 give supervisor (code 1) and 10 give user (code 2).
- R4: With none of bits 28, 2, 1 set, status bits [4:3] of 11 give the invalid-level code 3.
- R5: A virtual address in 0x80000000..0x9FFFFFFF sets `bypass`, and `paddr` is the address with its top three bits cleared.
- R6: A virtual address in 0xA0000000..0xBFFFFFFF sets `bypass` with the same mapping, and never faults, whatever the privilege level or alignment.
- R7: Any other address sets `to_tlb`, leaves `bypass` low, drives `paddr` to zero and never faults.
- R8: An access to the cached window when `priv_mode` is not kernel sets `fault_valid`, and `fault_addr` carries the virtual address.
- R9: An access to the cached window is misaligned when the low `size_log2` address bits are not all zero (size code 0 = 1 byte, 1 = 2, 2 = 4, 3 = 8); such an access faults even in kernel mode.
- R10: `fault_code` is 1 for an instruction fetch (`is_fetch` high) and 2 for a data access, and is 0 whenever `fault_valid` is low; `fault_addr` is 0 without a fault.
- R11: `uncacheable` is set exactly when virtual address bits 31 and 29 are both one.
- R12: The results for a request sampled at a rising edge with `req_valid` high appear after that edge with `out_valid` high; a cycle with `req_valid` low gives all outputs zero after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is presented this cycle |
| vaddr | input | 32 | Virtual address |
| size_log2 | input | 2 | Access size as log2 of the byte count |
| is_fetch | input | 1 | High for instruction fetch, low for data access |
| status | input | 32 | Processor status word |
| out_valid | output | 1 | Result word is valid |
| bypass | output | 1 | Address lies in an unmapped window |
| to_tlb | output | 1 | Address must be translated by the TLB |
| paddr | output | 32 | Physical address for unmapped windows, else zero |
| uncacheable | output | 1 | Request must not be cached |
| fault_valid | output | 1 | Address error raised |
| fault_code | output | 2 | 1 fetch address error, 2 data address error |
| fault_addr | output | 32 | Faulting virtual address |
| priv_mode | output | 2 | 0 kernel, 1 supervisor, 2 user, 3 invalid |

## Verification
Every result of this block is due exactly one clock after the request is sampled, since the only register on the path is the output stage. The bench drives inputs on the falling edge, and on the next falling edge compares each output with a value its own model computed from the previous request, so each check samples the word the intervening rising edge produced. Directed requests cover each window boundary, each status level and every size at the misaligned corners, and a random run mixes segments, levels and sizes.

// File: rtl/addr_seg_pkg.sv
package addr_seg_pkg;
  typedef enum logic [1:0] {
    PRIV_KERNEL = 2'd0,
    PRIV_SUPER  = 2'd1,
    PRIV_USER   = 2'd2,
    PRIV_BAD    = 2'd3
  } priv_e;

  localparam logic [1:0] FLT_NONE  = 2'd0;
  localparam logic [1:0] FLT_FETCH = 2'd1;
  localparam logic [1:0] FLT_DATA  = 2'd2;

  // status word fields
  localparam int ST_ERL_BIT = 2;
  localparam int ST_EXL_BIT = 1;
  localparam int ST_AUX_BIT = 28;
  localparam int ST_LVL_LO  = 3;

  // number of top address bits that select a window
  localparam int SEG_BITS = 3;
endpackage

// File: rtl/priv_decode.sv
module priv_decode
  import addr_seg_pkg::*;
#(
  parameter int STATUS_W = 32
) (
  input  logic [STATUS_W-1:0] status,
  output priv_e               level
);
  logic       force_kernel;
  logic [1:0] lvl_field;

  assign force_kernel = status[ST_AUX_BIT] | status[ST_ERL_BIT] | status[ST_EXL_BIT];
  assign lvl_field    = status[ST_LVL_LO +: 2];

  always_comb begin
    if (force_kernel) begin
      level = PRIV_KERNEL;
    end else begin
      unique case (lvl_field)
        2'b00:   level = PRIV_KERNEL;
        2'b01:   level = PRIV_SUPER;
        2'b10:   level = PRIV_USER;
        default: level = PRIV_BAD;
      endcase
    end
  end
endmodule

// File: rtl/seg_classify.sv
module seg_classify
  import addr_seg_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] vaddr,
  output logic              in_cached,
  output logic              in_uncached,
  output logic              no_cache,
  output logic [ADDR_W-1:0] phys
);
  localparam int TOP = ADDR_W - 1;
  logic [SEG_BITS-1:0] seg;

  assign seg         = vaddr[TOP -: SEG_BITS];
  assign in_cached   = (seg == 3'b100);
  assign in_uncached = (seg == 3'b101);
  assign no_cache    = vaddr[TOP] & vaddr[TOP-2];
  assign phys        = {{SEG_BITS{1'b0}}, vaddr[ADDR_W-SEG_BITS-1:0]};
endmodule

// File: rtl/align_check.sv
module align_check #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 2
) (
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [SIZE_W-1:0] size_log2,
  output logic              misaligned
);
  localparam int NSIZES = 1 << SIZE_W;
  logic [NSIZES-1:0] bad_at;

  for (genvar s = 0; s < NSIZES; s++) begin : g_size
    if (s == 0) begin : g_byte
      assign bad_at[s] = 1'b0;
    end else begin : g_wide
      assign bad_at[s] = |vaddr[s-1:0];
    end
  end

  assign misaligned = bad_at[size_log2];
endmodule

// File: rtl/addr_seg_check.sv
module addr_seg_check
  import addr_seg_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int SIZE_W   = 2,
  parameter int STATUS_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [ADDR_W-1:0]   vaddr,
  input  logic [SIZE_W-1:0]   size_log2,
  input  logic                is_fetch,
  input  logic [STATUS_W-1:0] status,
  output logic                out_valid,
  output logic                bypass,
  output logic                to_tlb,
  output logic [ADDR_W-1:0]   paddr,
  output logic                uncacheable,
  output logic                fault_valid,
  output logic [1:0]          fault_code,
  output logic [ADDR_W-1:0]   fault_addr,
  output logic [1:0]          priv_mode
);
  priv_e             lvl;
  logic              in_cached, in_uncached, no_cache, misaligned;
  logic [ADDR_W-1:0] phys;
  logic              unmapped, bad_access;

  priv_decode #(.STATUS_W(STATUS_W)) u_priv (
    .status (status),
    .level  (lvl)
  );

  seg_classify #(.ADDR_W(ADDR_W)) u_seg (
    .vaddr       (vaddr),
    .in_cached   (in_cached),
    .in_uncached (in_uncached),
    .no_cache    (no_cache),
    .phys        (phys)
  );

  align_check #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_align (
    .vaddr      (vaddr),
    .size_log2  (size_log2),
    .misaligned (misaligned)
  );

  assign unmapped   = in_cached | in_uncached;
  assign bad_access = in_cached & ((lvl != PRIV_KERNEL) | misaligned);

  always_ff @(posedge clk) begin
    if (rst || !req_valid) begin
      out_valid   <= 1'b0;
      bypass      <= 1'b0;
      to_tlb      <= 1'b0;
      paddr       <= '0;
      uncacheable <= 1'b0;
      fault_valid <= 1'b0;
      fault_code  <= FLT_NONE;
      fault_addr  <= '0;
      priv_mode   <= 2'd0;
    end else begin
      out_valid   <= 1'b1;
      bypass      <= unmapped;
      to_tlb      <= !unmapped;
      paddr       <= unmapped ? phys : '0;
      uncacheable <= no_cache;
      fault_valid <= bad_access;
      fault_code  <= bad_access ? (is_fetch ? FLT_FETCH : FLT_DATA) : FLT_NONE;
      fault_addr  <= bad_access ? vaddr : '0;
      priv_mode   <= lvl;
    end
  end

  assert_route_excl_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (bypass != to_tlb));

  assert_fault_cached_only_R8: assert property (@(posedge clk) disable iff (rst)
    fault_valid |-> (bypass && !uncacheable && paddr == {{SEG_BITS{1'b0}}, fault_addr[ADDR_W-SEG_BITS-1:0]}));

  assert_paddr_top_clear_R5: assert property (@(posedge clk) disable iff (rst)
    bypass |-> (paddr[ADDR_W-1 -: SEG_BITS] == '0));

  assert_code_pairing_R10: assert property (@(posedge clk) disable iff (rst)
    fault_valid == (fault_code != FLT_NONE));

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!bypass && !to_tlb && !fault_valid && !uncacheable));

  assert_latency_R12: assert property (@(posedge clk) disable iff (rst)
    out_valid == $past(req_valid && !rst));

  assert_uncache_track_R11: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (uncacheable == $past(vaddr[ADDR_W-1] && vaddr[ADDR_W-3])));
endmodule

// File: tb/addr_seg_check_tb_top.sv
module addr_seg_check_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] vaddr = '0;
  logic [1:0]  size_log2 = '0;
  logic        is_fetch = 1'b0;
  logic [31:0] status = '0;
  logic        out_valid, bypass, to_tlb, uncacheable, fault_valid;
  logic [31:0] paddr, fault_addr;
  logic [1:0]  fault_code, priv_mode;

  int checks = 0;
  int errors = 0;
  bit have_exp = 0;
  bit done = 0;

  logic        e_valid, e_bypass, e_tlb, e_unc, e_fault;
  logic [31:0] e_paddr, e_faddr;
  logic [1:0]  e_code, e_mode;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_seg_check dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .vaddr(vaddr),
    .size_log2(size_log2), .is_fetch(is_fetch), .status(status),
    .out_valid(out_valid), .bypass(bypass), .to_tlb(to_tlb), .paddr(paddr),
    .uncacheable(uncacheable), .fault_valid(fault_valid), .fault_code(fault_code),
    .fault_addr(fault_addr), .priv_mode(priv_mode)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R12 out_valid", 32'(out_valid), 32'(e_valid));
    chk("R5/R6 bypass", 32'(bypass), 32'(e_bypass));
    chk("R7 to_tlb", 32'(to_tlb), 32'(e_tlb));
    chk("R5 paddr", paddr, e_paddr);
    chk("R11 uncacheable", 32'(uncacheable), 32'(e_unc));
    chk("R8/R9 fault_valid", 32'(fault_valid), 32'(e_fault));
    chk("R10 fault_code", 32'(fault_code), 32'(e_code));
    chk("R8 fault_addr", fault_addr, e_faddr);
    chk("R2/R3/R4 priv_mode", 32'(priv_mode), 32'(e_mode));
  endtask

  // behavioural reference for one request
  task automatic model(input bit v, input logic [31:0] a, input int sz,
                       input bit f, input logic [31:0] st);
    int  m;
    bit  cached, uncached, misal;
    longint ua;
    ua = longint'(a);
    if ((st & 32'h1000_0006) != 0 || (st & 32'h18) == 0) m = 0;
    else if ((st & 32'h18) == 32'h08) m = 1;
    else if ((st & 32'h18) == 32'h10) m = 2;
    else m = 3;
    cached   = (ua >= 64'h8000_0000) && (ua < 64'hA000_0000);
    uncached = (ua >= 64'hA000_0000) && (ua < 64'hC000_0000);
    misal    = (ua % (longint'(1) << sz)) != 0;
    e_valid  = v;
    e_bypass = v && (cached || uncached);
    e_tlb    = v && !(cached || uncached);
    e_paddr  = e_bypass ? (a - (a / 32'h2000_0000) * 32'h2000_0000) : 32'h0;
    e_unc    = v && ((a & 32'hA000_0000) == 32'hA000_0000);
    e_fault  = v && cached && (m != 0 || misal);
    e_code   = e_fault ? (f ? 2'd1 : 2'd2) : 2'd0;
    e_faddr  = e_fault ? a : 32'h0;
    e_mode   = v ? 2'(m) : 2'd0;
  endtask

  task automatic step(input bit v, input logic [31:0] a, input int sz,
                      input bit f, input logic [31:0] st);
    @(negedge clk);
    if (have_exp) compare_all();
    req_valid = v; vaddr = a; size_log2 = 2'(sz); is_fetch = f; status = st;
    model(v, a, sz, f, st);
    have_exp = 1;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R1: outputs zero while held in reset
    chk("R1 out_valid in reset", 32'(out_valid), 32'h0);
    chk("R1 paddr in reset", paddr, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 out_valid after reset", 32'(out_valid), 32'h0);
    chk("R1 priv_mode after reset", 32'(priv_mode), 32'h0);

    // R2 kernel sources, R3 levels, R4 invalid level
    step(1, 32'h0040_1000, 2, 0, 32'h0000_0000);
    step(1, 32'h0040_1000, 2, 0, 32'h0000_0010);
    step(1, 32'h0040_1000, 2, 0, 32'h0000_0008);
    step(1, 32'h0040_1000, 2, 0, 32'h0000_0018);
    step(1, 32'h0040_1000, 2, 0, 32'h0000_0012);
    step(1, 32'h0040_1000, 2, 0, 32'h0000_001C);
    step(1, 32'h0040_1000, 2, 0, 32'h1000_0018);
    // R5 cached window edges in kernel
    step(1, 32'h8000_0000, 2, 0, 32'h0);
    step(1, 32'h9FFF_FFFC, 2, 1, 32'h0);
    // R6 uncached window: user mode, misaligned, no fault
    step(1, 32'hA000_0001, 3, 0, 32'h10);
    step(1, 32'hBFFF_FFFF, 2, 1, 32'h18);
    // R7 mapped neighbours of the windows, R11 high mapped
    step(1, 32'h7FFF_FFFF, 0, 0, 32'h10);
    step(1, 32'hC000_0000, 2, 0, 32'h0);
    step(1, 32'hE000_1234, 1, 1, 32'h10);
    // R8 privilege faults, R10 codes
    step(1, 32'h8123_4560, 2, 1, 32'h10);
    step(1, 32'h8123_4560, 2, 0, 32'h08);
    step(1, 32'h8123_4560, 2, 0, 32'h18);
    // R9 alignment in kernel for every size
    step(1, 32'h8000_0001, 0, 0, 32'h0);
    step(1, 32'h8000_0001, 1, 0, 32'h0);
    step(1, 32'h8000_0002, 2, 1, 32'h0);
    step(1, 32'h8000_0004, 3, 0, 32'h0);
    step(1, 32'h8000_0008, 3, 0, 32'h0);
    // R12 idle cycle between requests
    step(0, 32'h8000_0001, 3, 0, 32'h10);
    step(1, 32'h9000_0000, 0, 0, 32'h2);
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, st;
      a  = $urandom;
      st = $urandom & 32'h1000_001E;
      if (i % 3 == 0) a[31:30] = 2'b10;
      step(($urandom % 5) != 0, a, int'($urandom % 4), 1'($urandom), st);
    end
    step(0, 32'h0, 0, 0, 32'h0);
    step(0, 32'h0, 0, 0, 32'h0);
    done = 1;
    finish_run();
  end
endmodule